// File: doc/BRIEF.md
# Long Vector Element Sequencer

This block walks through the elements of a 64-element vector register for one vector instruction at a time. A start strobe presents the instruction kind and its length information. The block works out how many leading elements take part, then hands out element indices 0, 1, 2, ... one per cycle on a valid/ready stream. Each index comes with a byte address for memory transfers. A one-cycle done pulse closes the sequence. The datapath and the memory port that use these indices are outside the block.

There are two ways to get the element count. Vector operate instructions carry a 6-bit count in the instruction, and a value of zero there means the whole register. Vector load/store instructions carry a small register-select field. When that field is zero, the whole register is moved. Otherwise the caller supplies the contents of the selected integer register, and that value is the count, limited to 64. Memory addresses use unit stride: each element sits one element size beyond the previous one. The element size is taken at start and may be 1, 2, 4, 6 or 8 bytes.

The stream follows these back-pressure rules. The output `out_valid_o` stays high while a sequence is active. An element is consumed on a cycle where both valid and ready are high. While ready is low, the index and the address hold their values. The start strobe and the instruction fields are plain control pins, and they are sampled only when the block is idle.

Top module: `lvec_elem_seq`

## Requirements
- R1: After reset, `out_valid_o`, `active_o` and `done_o` are all low.
- R2: When `kind_i` = 0 (operate), a length field of 0 gives 64 elements, and a value of 1 to 63 gives exactly that many elements.
- R3: When `kind_i` = 1 (load/store) and `reg_sel_i` = 0, all 64 elements are sequenced, whatever the value on `reg_val_i`.
- R4: When `kind_i` = 1 and `reg_sel_i` is 1 to 3, the count is `reg_val_i`, and any value above 64 is taken as 64.
- R5: A resolved count of 0 produces no element. `done_o` pulses in the cycle right after the start is taken.
- R6: Indices run 0, 1, ... up to count-1 in order. An index advances only on a valid-and-ready cycle and holds while ready is low.
- R7: The address of index i is the base plus i times the element size, with both values sampled at start.
- R8: `done_o` is high for exactly one cycle, the cycle after the last element is accepted, and `out_valid_o` and `active_o` are low in that cycle.
- R9: A start that arrives while a sequence is active has no effect on that sequence.
- R10: `out_valid_o` and `active_o` are high from the cycle after an accepted start that has a nonzero count until the last element is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| kind_i | input | 1 | 0 = operate, 1 = load/store |
| len_fld_i | input | 6 | Immediate element count for operate instructions |
| reg_sel_i | input | 2 | Count register select for load/store; 0 means all elements |
| reg_val_i | input | 64 | Contents of the selected count register |
| base_i | input | 48 | Byte address of element 0 |
| esize_i | input | 4 | Element size in bytes |
| out_valid_o | output | 1 | Element index and address are valid |
| out_ready_i | input | 1 | Consumer accepts the current element |
| elem_idx_o | output | 6 | Current element index |
| elem_addr_o | output | 48 | Byte address of the current element |
| active_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The count logic is tested with operate lengths 0, 1, 10 and 63. These separate the "zero means all" rule from a literal count, and they also exercise both ends of the range. Load/store runs use a zero select field with a small register value, a register value of 0, small counts, exactly 64, and a very large value. These show whether the select field, the register path and the clamp act independently. Ready is driven either constantly high or randomly low, so that holding under stall can be told apart from free-running advance. Element sizes of 8, 6, 2 and 1 check that the address step follows the sampled size. One run raises start in the middle of a sequence to show that the live count is not replaced.

// File: rtl/lvec_seq_pkg.sv
package lvec_seq_pkg;
  typedef enum logic {
    KIND_OPERATE = 1'b0,
    KIND_MEMORY  = 1'b1
  } lvec_kind_e;
endpackage

// File: rtl/lvec_len_resolve.sv
module lvec_len_resolve
  import lvec_seq_pkg::*;
#(
  parameter int NELEM = 64,
  parameter int XW    = 64,
  parameter int RSW   = 2,
  localparam int IW   = $clog2(NELEM),
  localparam int CW   = IW + 1
) (
  input  lvec_kind_e       kind_i,
  input  logic [IW-1:0]    len_fld_i,
  input  logic [RSW-1:0]   reg_sel_i,
  input  logic [XW-1:0]    reg_val_i,
  output logic [CW-1:0]    cnt_o
);
  localparam logic [CW-1:0] FULL    = CW'(NELEM);
  localparam logic [XW-1:0] FULL_XW = XW'(NELEM);

  logic [CW-1:0] imm_cnt;
  logic [CW-1:0] reg_cnt;

  always_comb begin
    if (len_fld_i == '0) imm_cnt = FULL;
    else                 imm_cnt = {1'b0, len_fld_i};
  end

  always_comb begin
    if (reg_sel_i == '0)            reg_cnt = FULL;
    else if (reg_val_i > FULL_XW)   reg_cnt = FULL;
    else                            reg_cnt = reg_val_i[CW-1:0];
  end

  assign cnt_o = (kind_i == KIND_MEMORY) ? reg_cnt : imm_cnt;
endmodule

// File: rtl/lvec_walker.sv
module lvec_walker #(
  parameter int NELEM = 64,
  parameter int AW    = 48,
  parameter int SW    = 4,
  localparam int IW   = $clog2(NELEM),
  localparam int CW   = IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] base_i,
  input  logic [SW-1:0] esize_i,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [IW-1:0] idx_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          done_o
);
  logic          busy_q;
  logic          done_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] last_q;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] esz_q;
  logic          fire;
  logic          at_last;
  logic          take;
  logic [CW-1:0] cnt_m1;

  assign fire    = busy_q && ready_i;
  assign at_last = (idx_q == last_q);
  assign take    = start_i && !busy_q;
  assign cnt_m1  = cnt_i - CW'(1);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      addr_q <= '0;
      esz_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (fire) begin
        if (at_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q  <= idx_q + IW'(1);
          addr_q <= addr_q + AW'(esz_q);
        end
      end else if (take) begin
        if (cnt_i == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          last_q <= cnt_m1[IW-1:0];
          addr_q <= base_i;
          esz_q  <= esize_i;
        end
      end
    end
  end

  assign valid_o = busy_q;
  assign busy_o  = busy_q;
  assign idx_o   = idx_q;
  assign addr_o  = addr_q;
  assign done_o  = done_q;

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(idx_o) && $stable(addr_o));

  p_first_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> idx_q == '0);

  p_addr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !at_last |=> addr_o == $past(addr_o) + AW'(esz_q));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o && !busy_o);

  p_busy_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !busy_q || $stable(last_q));
endmodule

// File: rtl/lvec_elem_seq.sv
module lvec_elem_seq
  import lvec_seq_pkg::*;
#(
  parameter int NELEM = 64,
  parameter int XW    = 64,
  parameter int RSW   = 2,
  parameter int AW    = 48,
  parameter int SW    = 4,
  localparam int IW   = $clog2(NELEM),
  localparam int CW   = IW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           kind_i,
  input  logic [IW-1:0]  len_fld_i,
  input  logic [RSW-1:0] reg_sel_i,
  input  logic [XW-1:0]  reg_val_i,
  input  logic [AW-1:0]  base_i,
  input  logic [SW-1:0]  esize_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [IW-1:0]  elem_idx_o,
  output logic [AW-1:0]  elem_addr_o,
  output logic           active_o,
  output logic           done_o
);
  logic [CW-1:0] cnt;
  lvec_kind_e    kind;

  assign kind = lvec_kind_e'(kind_i);

  lvec_len_resolve #(.NELEM(NELEM), .XW(XW), .RSW(RSW)) i_len (
    .kind_i   (kind),
    .len_fld_i(len_fld_i),
    .reg_sel_i(reg_sel_i),
    .reg_val_i(reg_val_i),
    .cnt_o    (cnt)
  );

  lvec_walker #(.NELEM(NELEM), .AW(AW), .SW(SW)) i_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .cnt_i  (cnt),
    .base_i (base_i),
    .esize_i(esize_i),
    .valid_o(out_valid_o),
    .ready_i(out_ready_i),
    .idx_o  (elem_idx_o),
    .addr_o (elem_addr_o),
    .busy_o (active_o),
    .done_o (done_o)
  );

  p_cnt_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cnt <= CW'(NELEM));

  p_zero_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !active_o && cnt == '0 |=> done_o && !out_valid_o);

  p_full_mem_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && kind_i && reg_sel_i == '0 |-> cnt == CW'(NELEM));
endmodule

// File: tb/test_lvec_elem_seq.sv
module test_lvec_elem_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        kind_i = 1'b0;
  logic [5:0]  len_fld_i = '0;
  logic [1:0]  reg_sel_i = '0;
  logic [63:0] reg_val_i = '0;
  logic [47:0] base_i = '0;
  logic [3:0]  esize_i = '0;
  logic        out_ready_i = 1'b0;
  logic        out_valid_o;
  logic [5:0]  elem_idx_o;
  logic [47:0] elem_addr_o;
  logic        active_o;
  logic        done_o;

  int total = 0;
  int bad = 0;
  int seen = 0;
  int dones = 0;
  bit rmode = 1'b1;
  int cyc = 0;

  bit          m_busy = 1'b0;
  bit          m_done = 1'b0;
  int          m_idx = 0;
  int          m_n = 0;
  logic [47:0] m_addr = '0;
  logic [47:0] m_sz = '0;

  always #5 clk_i = ~clk_i;

  lvec_elem_seq i_lvec_elem_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .kind_i(kind_i),
    .len_fld_i(len_fld_i), .reg_sel_i(reg_sel_i), .reg_val_i(reg_val_i),
    .base_i(base_i), .esize_i(esize_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .elem_idx_o(elem_idx_o),
    .elem_addr_o(elem_addr_o), .active_o(active_o), .done_o(done_o)
  );

  function automatic int want_count(bit k, int len, int sel, logic [63:0] rv);
    if (!k) return (len == 0) ? 64 : len;
    if (sel == 0) return 64;
    if (rv > 64) return 64;
    return int'(rv);
  endfunction

  // reference model, updated on every rising edge from bench-driven inputs
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_idx = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (out_ready_i) begin
          if (m_idx == m_n - 1) begin m_busy = 0; m_done = 1; end
          else begin m_idx++; m_addr = m_addr + m_sz; end
        end
      end else if (start_i) begin
        m_n = want_count(kind_i, int'(len_fld_i), int'(reg_sel_i), reg_val_i);
        if (m_n == 0) m_done = 1;
        else begin
          m_busy = 1; m_idx = 0; m_addr = base_i; m_sz = 48'(esize_i);
        end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid_o == m_busy, "R10", "valid", out_valid_o, m_busy);
    chk(active_o == m_busy, "R10", "active", active_o, m_busy);
    chk(done_o == m_done, "R8", "done", done_o, m_done);
    if (m_busy) begin
      chk(int'(elem_idx_o) == m_idx, "R6", "index", elem_idx_o, m_idx);
      chk(elem_addr_o == m_addr, "R7", "address", elem_addr_o, m_addr);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    compare();
    out_ready_i = rmode ? 1'b1 : (($urandom % 4) != 0);
    if (out_valid_o && out_ready_i) seen++;
    if (done_o) dones++;
  endtask

  task automatic run(bit k, logic [5:0] len, logic [1:0] sel, logic [63:0] rv,
                     logic [47:0] b, logic [3:0] sz, int expn, bit intrude,
                     bit rm, string req);
    rmode = rm;
    seen = 0; dones = 0;
    kind_i = k; len_fld_i = len; reg_sel_i = sel; reg_val_i = rv;
    base_i = b; esize_i = sz; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    for (int c = 0; c < 400 && dones == 0; c++) begin
      if (intrude && c == 3) begin
        start_i = 1'b1; kind_i = 1'b0; len_fld_i = 6'd3; base_i = '0; esize_i = 4'd1;
      end else start_i = 1'b0;
      tick();
    end
    start_i = 1'b0;
    tick();
    chk(seen == expn, req, "element count", seen, expn);
    chk(dones == 1, "R8", "done pulses", dones, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    compare();
    chk(!out_valid_o && !active_o && !done_o, "R1", "idle after reset",
        {out_valid_o, active_o, done_o}, 0);
    rst_ni = 1'b1;
    tick();
    run(1'b0, 6'd0,  2'd0, 64'd9,    48'h1000, 4'd8, 64, 0, 0, "R2");
    run(1'b0, 6'd1,  2'd0, 64'd0,    48'h2000, 4'd4, 1,  0, 1, "R2");
    run(1'b0, 6'd63, 2'd0, 64'd0,    48'h3000, 4'd2, 63, 0, 0, "R2");
    run(1'b1, 6'd7,  2'd0, 64'd5,    48'h4000, 4'd6, 64, 0, 0, "R3");
    run(1'b1, 6'd0,  2'd2, 64'd0,    48'h5000, 4'd8, 0,  0, 1, "R5");
    run(1'b1, 6'd0,  2'd1, 64'd17,   48'h6001, 4'd2, 17, 0, 0, "R4");
    run(1'b1, 6'd0,  2'd3, 64'd1000, 48'h7000, 4'd8, 64, 0, 1, "R4");
    run(1'b1, 6'd0,  2'd3, 64'd64,   48'h8000, 4'd4, 64, 0, 0, "R4");
    run(1'b0, 6'd10, 2'd0, 64'd0,    48'h9000, 4'd6, 10, 1, 0, "R9");
    run(1'b1, 6'd0,  2'd1, 64'd1,    48'hA000, 4'd1, 1,  0, 1, "R4");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule